// File: doc/BRIEF.md
# Screen-to-Plane Coordinate Table Generator

This block turns a view description (a centre point on the complex plane and a per-pixel step) into two lookup tables. One table holds the plane X value of every screen column. The other holds the plane Y value of every screen row. A start pulse at the beginning of each frame triggers a fresh fill. Once the tables are complete, a ready flag rises.

After that point, both a pixel renderer and a cursor lookup read the same stored values. The renderer reads through one port and the cursor lookup through another. A mouse click therefore resolves to plane coordinates without any multiplier and without recomputing the mapping.

Filling is incremental. The first column takes the left edge, which is the centre minus half a screen width of steps. Every later column adds one step. Rows are built the same way from the top edge and share the column counter. All values are signed two's complement with FRAC fraction bits, and each is clamped to the interval from -2.0 to +2.0 before it is stored.

Top module: `coord_table_gen`

## Requirements
- R1: During and right after reset, `ready_o` is low and all four read outputs are zero.
- R2: A start pulse drives `ready_o` low on the next clock edge. `ready_o` rises exactly COLS clock edges after the edge that sampled the start pulse, and it stays high until the next start pulse.
- R3: The X entry for column i is clamp(cx - step*(COLS/2) + i*step), for 0 <= i < COLS.
- R4: The Y entry for row j is clamp(cy - step*(ROWS/2) + j*step), for 0 <= j < ROWS. The Y table is written only at addresses below ROWS.
- R5: clamp() limits each value to the range -2^(FRAC+1) to +2^(FRAC+1). With FRAC fraction bits, this range is -2.0 to +2.0.
- R6: The centre and step are sampled only on the clock edge that sees the start pulse. Changes to them during a fill have no effect on the stored tables.
- R7: The render port returns the X entry for `rd_col_i` and the Y entry for `rd_row_i` one clock edge after the indices are presented.
- R8: The cursor port returns both plane coordinates for (`cur_col_i`, `cur_row_i`) one clock edge after the indices are presented.
- R9: If `ready_o` was low at the edge that samples a read, that read returns zero on both ports.
- R10: A column index of COLS or more, or a row index of ROWS or more, reads as zero.
- R11: A start pulse that arrives during a fill restarts the fill from index 0, using the newly sampled centre and step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a table fill |
| cx_i | input | W | Signed view centre, X |
| cy_i | input | W | Signed view centre, Y |
| step_i | input | W | Unsigned plane distance per pixel |
| ready_o | output | 1 | Tables complete and valid |
| rd_col_i | input | IDXW | Render column index |
| rd_row_i | input | IDXW | Render row index |
| rd_x_o | output | W | Render X value |
| rd_y_o | output | W | Render Y value |
| cur_col_i | input | IDXW | Cursor column index |
| cur_row_i | input | IDXW | Cursor row index |
| cur_x_o | output | W | Cursor X value |
| cur_y_o | output | W | Cursor Y value |

## Verification
The bench uses COLS=40 and ROWS=24, with W=35 and FRAC=32 left at their default values. Because 40 is not a power of two, the 6-bit index can reach 63, so out-of-range column and row reads can be exercised. The small table size also allows the whole table to be read back after every one of many frames.

Step sizes go up to about 2^30. At this table width that is large enough to drive both edges into saturation, which exercises the clamp at the real number format. The bench also covers a step of zero, a restart issued in the middle of a fill, and input changes made during a fill.

// File: rtl/coord_gen_pkg.sv
// Package: shared types for the coordinate table generator.
// Assumes nothing beyond IEEE 1800-2017.
package coord_gen_pkg;
    typedef enum logic {ST_IDLE, ST_FILL} fill_state_e;
endpackage

// File: rtl/coord_fill_seq.sv
// Module: coord_fill_seq
// Walks an index from 0 to COLS-1 after a start pulse.
// Produces one clamped X value every cycle, and one clamped Y value every
// cycle while the index is below ROWS.
// Assumes ROWS <= COLS and FRAC + 2 < W.
module coord_fill_seq
    import coord_gen_pkg::*;
#(
    parameter int COLS = 800,
    parameter int ROWS = 600,
    parameter int W    = 35,
    parameter int FRAC = 32,
    parameter int IDXW = $clog2(COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [W-1:0] cx_i,
    input  logic signed [W-1:0] cy_i,
    input  logic        [W-1:0] step_i,
    output logic                ready_o,
    output logic                wr_x_en_o,
    output logic                wr_y_en_o,
    output logic [IDXW-1:0]     wr_addr_o,
    output logic signed [W-1:0] wr_x_o,
    output logic signed [W-1:0] wr_y_o
);
    localparam int ACCW = W + IDXW + 2;
    localparam logic [IDXW-1:0] LAST = IDXW'(COLS - 1);
    localparam logic signed [ACCW-1:0] HALF_X = ACCW'(COLS / 2);
    localparam logic signed [ACCW-1:0] HALF_Y = ACCW'(ROWS / 2);
    localparam logic signed [ACCW-1:0] LIM_P =
        {{(ACCW-FRAC-2){1'b0}}, 2'b10, {FRAC{1'b0}}};
    localparam logic signed [ACCW-1:0] LIM_N = -LIM_P;

    fill_state_e            state;
    logic [IDXW-1:0]        idx;
    logic signed [ACCW-1:0] acc_x, acc_y, step_q;
    logic signed [ACCW-1:0] step_ext, left_edge, top_edge;

    // Clamp a wide accumulator value into the -2.0 to +2.0 range.
    function automatic logic signed [W-1:0] clamp(input logic signed [ACCW-1:0] v);
        if (v > LIM_P)      return W'(LIM_P);
        else if (v < LIM_N) return W'(LIM_N);
        else                return v[W-1:0];
    endfunction

    // Compute the first column and first row values from the live inputs.
    always_comb begin
        step_ext  = $signed({{(ACCW-W){1'b0}}, step_i});
        left_edge = ACCW'(cx_i) - step_ext * HALF_X;
        top_edge  = ACCW'(cy_i) - step_ext * HALF_Y;
    end

    // Fill state machine: load the edges on start, then step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            acc_x   <= '0;
            acc_y   <= '0;
            step_q  <= '0;
            ready_o <= 1'b0;
        end else if (start_i) begin
            state   <= ST_FILL;
            idx     <= '0;
            acc_x   <= left_edge;
            acc_y   <= top_edge;
            step_q  <= step_ext;
            ready_o <= 1'b0;
        end else if (state == ST_FILL) begin
            acc_x <= acc_x + step_q;
            acc_y <= acc_y + step_q;
            if (idx == LAST) begin
                state   <= ST_IDLE;
                ready_o <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Drive the table write ports from the current accumulators.
    always_comb begin
        wr_x_en_o = (state == ST_FILL);
        wr_y_en_o = (state == ST_FILL) && (int'(idx) < ROWS);
        wr_addr_o = idx;
        wr_x_o    = clamp(acc_x);
        wr_y_o    = clamp(acc_y);
    end

    assert_start_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ready_o);
    assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> ready_o);
    assert_restart_from_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (wr_addr_o == '0) && wr_x_en_o);
endmodule

// File: rtl/coord_table.sv
// Module: coord_table
// One memory with a single write port and two registered read ports.
// A read returns zero when ready_i is low or when the address is at or
// beyond DEPTH.
// Assumes the writer keeps ready_i low while it is writing.
module coord_table #(
    parameter int DEPTH = 800,
    parameter int W     = 35,
    parameter int FRAC  = 32,
    parameter int AW    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic signed [W-1:0] wdata_i,
    input  logic                ready_i,
    input  logic [AW-1:0]       ra_a_i,
    output logic signed [W-1:0] rd_a_o,
    input  logic [AW-1:0]       ra_b_i,
    output logic signed [W-1:0] rd_b_o
);
    localparam logic signed [W-1:0] LIM_P = {{(W-FRAC-2){1'b0}}, 2'b10, {FRAC{1'b0}}};

    logic signed [W-1:0] mem [DEPTH];

    // Store one entry per write cycle.
    always_ff @(posedge clk) begin
        if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
    end

    // Registered read ports, gated by ready and by the address range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_a_o <= '0;
            rd_b_o <= '0;
        end else begin
            rd_a_o <= (ready_i && int'(ra_a_i) < DEPTH) ? mem[ra_a_i] : '0;
            rd_b_o <= (ready_i && int'(ra_b_i) < DEPTH) ? mem[ra_b_i] : '0;
        end
    end

    assert_wr_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> int'(waddr_i) < DEPTH);
    assert_wr_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (wdata_i <= LIM_P) && (wdata_i >= -LIM_P));
    assert_no_write_when_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |-> !we_i);
endmodule

// File: rtl/coord_table_gen.sv
// Module: coord_table_gen (top)
// Fills an X table (COLS entries) and a Y table (ROWS entries) after each
// start pulse. Serves a render port and a cursor port, each with one cycle
// of read latency.
// Assumes ROWS <= COLS. Both index widths follow COLS.
module coord_table_gen #(
    parameter int COLS = 800,
    parameter int ROWS = 600,
    parameter int W    = 35,
    parameter int FRAC = 32,
    parameter int IDXW = $clog2(COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [W-1:0] cx_i,
    input  logic signed [W-1:0] cy_i,
    input  logic        [W-1:0] step_i,
    output logic                ready_o,
    input  logic [IDXW-1:0]     rd_col_i,
    input  logic [IDXW-1:0]     rd_row_i,
    output logic signed [W-1:0] rd_x_o,
    output logic signed [W-1:0] rd_y_o,
    input  logic [IDXW-1:0]     cur_col_i,
    input  logic [IDXW-1:0]     cur_row_i,
    output logic signed [W-1:0] cur_x_o,
    output logic signed [W-1:0] cur_y_o
);
    logic                wx_en, wy_en;
    logic [IDXW-1:0]     waddr;
    logic signed [W-1:0] wx, wy;

    coord_fill_seq #(.COLS(COLS), .ROWS(ROWS), .W(W), .FRAC(FRAC), .IDXW(IDXW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cx_i(cx_i), .cy_i(cy_i), .step_i(step_i), .ready_o(ready_o),
        .wr_x_en_o(wx_en), .wr_y_en_o(wy_en), .wr_addr_o(waddr),
        .wr_x_o(wx), .wr_y_o(wy)
    );

    coord_table #(.DEPTH(COLS), .W(W), .FRAC(FRAC), .AW(IDXW)) xtab_i (
        .clk(clk), .rst_n(rst_n), .we_i(wx_en), .waddr_i(waddr), .wdata_i(wx),
        .ready_i(ready_o), .ra_a_i(rd_col_i), .rd_a_o(rd_x_o),
        .ra_b_i(cur_col_i), .rd_b_o(cur_x_o)
    );

    coord_table #(.DEPTH(ROWS), .W(W), .FRAC(FRAC), .AW(IDXW)) ytab_i (
        .clk(clk), .rst_n(rst_n), .we_i(wy_en), .waddr_i(waddr), .wdata_i(wy),
        .ready_i(ready_o), .ra_a_i(rd_row_i), .rd_a_o(rd_y_o),
        .ra_b_i(cur_row_i), .rd_b_o(cur_y_o)
    );

    assert_reads_zero_unready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ready_o) |-> (rd_x_o == '0) && (rd_y_o == '0) && (cur_x_o == '0) && (cur_y_o == '0));
    assert_ready_after_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(wx_en));
endmodule

// File: tb/coord_table_gen_tb_top.sv
module coord_table_gen_tb_top;
    localparam int COLS = 40;
    localparam int ROWS = 24;
    localparam int W    = 35;
    localparam int FRAC = 32;
    localparam int IDXW = $clog2(COLS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic signed [W-1:0] cx_i = '0, cy_i = '0;
    logic [W-1:0] step_i = '0;
    logic ready_o;
    logic [IDXW-1:0] rd_col_i = '0, rd_row_i = '0, cur_col_i = '0, cur_row_i = '0;
    logic signed [W-1:0] rd_x_o, rd_y_o, cur_x_o, cur_y_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coord_table_gen #(.COLS(COLS), .ROWS(ROWS), .W(W), .FRAC(FRAC), .IDXW(IDXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cx_i(cx_i), .cy_i(cy_i), .step_i(step_i), .ready_o(ready_o),
        .rd_col_i(rd_col_i), .rd_row_i(rd_row_i), .rd_x_o(rd_x_o), .rd_y_o(rd_y_o),
        .cur_col_i(cur_col_i), .cur_row_i(cur_row_i), .cur_x_o(cur_x_o), .cur_y_o(cur_y_o)
    );

    // Limit to plus or minus 2.0 (R5).
    function automatic longint clampl(longint v);
        longint lim = longint'(1) <<< (FRAC + 1);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic longint exp_x(longint cx, longint st, int i);
        if (i >= COLS) return 0;
        return clampl(cx - st * (COLS / 2) + st * i);
    endfunction

    function automatic longint exp_y(longint cy, longint st, int j);
        if (j >= ROWS) return 0;
        return clampl(cy - st * (ROWS / 2) + st * j);
    endfunction

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse start with the given view, then scramble the inputs during the fill (R6).
    task automatic launch(longint cx, longint cy, longint st);
        @(negedge clk);
        cx_i = W'(cx); cy_i = W'(cy); step_i = W'(st); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cx_i = ~cx_i; cy_i = cy_i + 35'sd12345; step_i = step_i + 35'd777;
        check("R2 ready low after start", longint'(ready_o), 0);
    endtask

    // Finish a fill started by launch(), timing the ready rise (R2, R9).
    task automatic finish_fill();
        rd_col_i = '0; rd_row_i = '0; cur_col_i = '0; cur_row_i = '0;
        @(negedge clk);
        check("R9 render x zero during fill", longint'(rd_x_o), 0);
        check("R9 cursor y zero during fill", longint'(cur_y_o), 0);
        repeat (COLS - 2) @(negedge clk);
        check("R2 ready still low at COLS-1", longint'(ready_o), 0);
        @(negedge clk);
        check("R2 ready high at COLS", longint'(ready_o), 1);
    endtask

    // Read the whole index range through both ports and compare (R3, R4, R7, R8, R10).
    task automatic verify(longint cx, longint cy, longint st);
        for (int i = 0; i < (1 << IDXW); i++) begin
            rd_col_i = IDXW'(i); rd_row_i = IDXW'(i);
            cur_col_i = IDXW'((1 << IDXW) - 1 - i); cur_row_i = IDXW'($urandom_range(0, (1 << IDXW) - 1));
            @(negedge clk);
            check(i < COLS ? "R3 R7 render x" : "R10 render x range", longint'(rd_x_o), exp_x(cx, st, i));
            check(i < ROWS ? "R4 R7 render y" : "R10 render y range", longint'(rd_y_o), exp_y(cy, st, i));
            check("R8 cursor x", longint'(cur_x_o), exp_x(cx, st, int'(cur_col_i)));
            check("R8 cursor y", longint'(cur_y_o), exp_y(cy, st, int'(cur_row_i)));
        end
        check("R2 ready holds", longint'(ready_o), 1);
    endtask

    task automatic frame(longint cx, longint cy, longint st);
        launch(cx, cy, st);
        finish_fill();
        verify(cx, cy, st);
    endtask

    // Watchdog: count cycles and end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        longint cx, cy, st;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 ready in reset", longint'(ready_o), 0);
        check("R1 render x in reset", longint'(rd_x_o), 0);
        check("R1 cursor y in reset", longint'(cur_y_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", longint'(ready_o), 0);
        check("R1 render y after reset", longint'(rd_y_o), 0);

        // Directed corner cases: centre view, zero step, saturating step.
        frame(0, 0, longint'(1) <<< 26);
        frame(longint'(1) <<< 32, -(longint'(1) <<< 31), 0);
        frame(0, 0, longint'(1) <<< 29);
        frame(-(longint'(1) <<< 33), longint'(1) <<< 33, longint'(1) <<< 28);

        // Restart in the middle of a fill (R11).
        launch(longint'(1) <<< 30, longint'(1) <<< 30, longint'(1) <<< 27);
        repeat (10) @(negedge clk);
        check("R11 ready low mid fill", longint'(ready_o), 0);
        cx = -(longint'(3) <<< 30); cy = longint'(5) <<< 28; st = longint'(3) <<< 24;
        frame(cx, cy, st);

        // Constrained random views.
        for (int n = 0; n < 12; n++) begin
            cx = (longint'($urandom) <<< 2) - (longint'(1) <<< 33);
            cy = (longint'($urandom) <<< 2) - (longint'(1) <<< 33);
            st = longint'($urandom) >> $urandom_range(2, 10);
            frame(cx, cy, st);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule